// File: doc/BRIEF.md
# Integer Ratio Clock Generator

This block derives slower clock domains from one fast input clock. Each of its two channels divides the fast clock by an integer ratio that is fixed when the design is elaborated. The defaults are 13 and 52, and both channels run at the same time from the same master clock. For each channel the block drives three outputs: a slow clock with a known phase relation to the fast clock, a one-cycle tick that can be used as a clock enable in place of that clock, and a ready flag in the fast domain.

Every output comes from the same oscillator, so data passing between the fast domain and a slow domain needs no metastability synchronizer. The ready flag is high in the one fast cycle whose closing edge is also the slow clock's rising edge. Fast-domain logic hands data to the slow side, or takes it from the slow side, only while ready is high. The fast clock itself is also passed straight through, so the consumer can see the whole clock family at one boundary.

The reset input is active low. It is asserted asynchronously, and the surrounding logic must release it in step with the fast clock. Cycle numbering in the requirements starts at the fast cycle in which reset is released. In that cycle the count of rising edges since release is 0.

Top module: `ratio_clock_gen`

## Requirements
- R1: Channel 0 divides by `DIV_A` (default 13) and channel 1 by `DIV_B` (default 52). Both are elaboration parameters, run at the same time from `clk_i` and do not affect each other. Bit i of every per-channel output vector belongs to channel i.
- R2: `fast_clk_o` follows `clk_i` at all times: high while `clk_i` is high and low while it is low.
- R3: While `rst_ni` is low, every `ready_o`, `slow_clk_o` and `slow_tick_o` bit is 0.
- R4: For a channel with ratio N, let k be the number of rising edges of `clk_i` since reset release. `ready_o` is 1 exactly when k mod N equals N-1, so it is high for one fast cycle in every N.
- R5: After reset release, `ready_o` first goes high after the (N-1)th rising edge. That is the Nth fast cycle, counting the cycle in which reset is released.
- R6: `slow_clk_o` rises only on the fast edge that closes a cycle in which `ready_o` is high, and it rises on every such edge.
- R7: Once it starts, `slow_clk_o` is high for floor(N/2) fast cycles and low for the remaining N-floor(N/2) cycles of each period. For example, N=3 gives 1 cycle high and 2 low. The output stays low until its first rise at k = N.
- R8: `slow_tick_o` is 1 exactly in the fast cycle that follows a cycle with `ready_o` high, so it is high when k is at least N and k mod N is 0.
- R9: A ratio below 2 stops elaboration with an error.
- R10: Pulling `rst_ni` low in the middle of a run clears all outputs at once, without waiting for a clock edge. After release, the sequence starts again as described in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast master clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| fast_clk_o | output | 1 | Pass-through of the fast clock |
| slow_clk_o | output | 2 | Divided clock per channel |
| slow_tick_o | output | 2 | One-fast-cycle enable per slow period, per channel |
| ready_o | output | 2 | Fast-domain transfer qualifier per channel |

## Verification
Any fault in a channel's modulo counter changes the cycle in which `ready_o` rises. With a ratio of N, a counter that skips a state, wraps at the wrong value or leaves reset with the wrong value shows up within N fast cycles. A wrong phase-generation state shows up one cycle later as a misplaced `slow_tick_o`, as a `slow_clk_o` rise that does not follow ready, or as a high phase of the wrong length. An arming fault makes a shortened slow pulse appear before edge N. The bench compares every output against a model built on the count of edges since reset, once per fast cycle. It runs ratios 13, 52, 3 and 2, so both odd and even ratios are covered, including the smallest legal one.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

  // Counter width for a modulo-n count; at least one bit.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  typedef struct packed {
    logic ready;
    logic slow;
    logic tick;
  } chan_out_t;

endpackage

// File: rtl/rcg_counter.sv
module rcg_counter #(
  parameter int unsigned DIV = 13,
  localparam int unsigned CW = rcg_pkg::cnt_width(DIV)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          wrap_o
);

  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  // next-state
  always_comb begin
    at_last = (cnt_q == LAST);
    if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_nxt_o = cnt_d;
  assign wrap_o    = at_last;

endmodule

// File: rtl/rcg_phase.sv
module rcg_phase #(
  parameter int unsigned DIV = 13,
  localparam int unsigned CW = rcg_pkg::cnt_width(DIV)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_nxt_i,
  input  logic          wrap_i,
  output logic          slow_o,
  output logic          tick_o
);

  localparam logic [CW-1:0] HALF = CW'(DIV / 2);

  logic armed_q, armed_d;
  logic slow_q, slow_d;
  logic tick_q, tick_d;
  logic live;

  // next-state: slow high for the first HALF counts of each full period
  always_comb begin
    live    = armed_q | wrap_i;
    armed_d = live;
    slow_d  = live & (cnt_nxt_i < HALF);
    tick_d  = wrap_i;
  end

  // register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      slow_q  <= 1'b0;
      tick_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      slow_q  <= slow_d;
      tick_q  <= tick_d;
    end
  end

  assign slow_o = slow_q;
  assign tick_o = tick_q;

endmodule

// File: rtl/rcg_channel.sv
module rcg_channel #(
  parameter int unsigned DIV = 13,
  localparam int unsigned CW = rcg_pkg::cnt_width(DIV)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output rcg_pkg::chan_out_t  out_o
);

  // R9: ratios below 2 are refused at elaboration
  if (DIV < 2) begin : g_bad_div
    $error("rcg_channel: ratio must be at least 2");
  end

  logic [CW-1:0] cnt_nxt;
  logic          wrap;
  logic          slow;
  logic          tick;

  rcg_counter #(.DIV(DIV)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_nxt_o (cnt_nxt),
    .wrap_o    (wrap)
  );

  rcg_phase #(.DIV(DIV)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cnt_nxt_i (cnt_nxt),
    .wrap_i    (wrap),
    .slow_o    (slow),
    .tick_o    (tick)
  );

  assign out_o.ready = wrap;
  assign out_o.slow  = slow;
  assign out_o.tick  = tick;

  a_r4_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> !wrap);

  a_r6_rise_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> $rose(slow));

  a_r6_rise_only_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slow) |-> $past(wrap));

  a_r8_tick_follows_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> tick);

  a_r8_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> !tick);

endmodule

// File: rtl/ratio_clock_gen.sv
module ratio_clock_gen #(
  parameter int unsigned DIV_A = 13,
  parameter int unsigned DIV_B = 52
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       fast_clk_o,
  output logic [1:0] slow_clk_o,
  output logic [1:0] slow_tick_o,
  output logic [1:0] ready_o
);

  localparam int unsigned NCH = 2;
  localparam int unsigned DIVS [NCH] = '{DIV_A, DIV_B};

  // R2: the fast clock leaves unchanged
  assign fast_clk_o = clk_i;

  // R1: one independent channel per ratio
  for (genvar i = 0; i < NCH; i++) begin : g_chan
    rcg_pkg::chan_out_t co;

    rcg_channel #(.DIV(DIVS[i])) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .out_o  (co)
    );

    assign slow_clk_o[i]  = co.slow;
    assign slow_tick_o[i] = co.tick;
    assign ready_o[i]     = co.ready;
  end

endmodule

// File: tb/sim_ratio_clock_gen.sv
`timescale 1ns/1ps
module sim_ratio_clock_gen;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;   // 200 MHz

  logic       f0, f1;
  logic [1:0] s0, t0, r0, s1, t1, r1;

  // u0: defaults 13/52; u1: odd 3 and minimum 2
  ratio_clock_gen u0 (.clk_i(clk), .rst_ni(rst_n), .fast_clk_o(f0),
                      .slow_clk_o(s0), .slow_tick_o(t0), .ready_o(r0));
  ratio_clock_gen #(.DIV_A(3), .DIV_B(2)) u1 (.clk_i(clk), .rst_ni(rst_n), .fast_clk_o(f1),
                      .slow_clk_o(s1), .slow_tick_o(t1), .ready_o(r1));

  int tests = 0;
  int fails = 0;
  int k = 0;          // rising edges since reset release
  bit done = 1'b0;

  // Behavioural model clock: edge count since release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) k = 0;
    else        k = k + 1;
  end

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at k=%0d: actual=%b expected=%b", req, what, k, act, exp);
    end
  endtask

  task automatic chan(input int n, input logic rdy, input logic slw, input logic tck, input string nm);
    logic er, es, et;
    string rr, rs;
    er = (k % n) == n - 1;
    es = (k >= n) && ((k % n) < n / 2);
    et = (k >= n) && ((k % n) == 0);
    if (!rst_n) begin
      chk("R3", rdy, 1'b0, {nm, " ready in reset"});
      chk("R3", slw, 1'b0, {nm, " slow in reset"});
      chk("R3", tck, 1'b0, {nm, " tick in reset"});
    end else begin
      rr = (k == n - 1) ? "R5" : "R4";
      rs = ((k % n) == 0) ? "R6" : "R7";
      chk(rr, rdy, er, {nm, " ready"});
      chk(rs, slw, es, {nm, " slow"});
      chk("R8", tck, et, {nm, " tick"});
    end
  endtask

  // compare every cycle, 1 ns after the falling edge
  always @(negedge clk) begin
    if (!done) begin
      #1;
      chk("R2", f0, 1'b0, "fast_clk low phase u0");
      chk("R2", f1, 1'b0, "fast_clk low phase u1");
      // R1: four channels, four ratios, one clock
      chan(13, r0[0], s0[0], t0[0], "u0.ch0(13)");
      chan(52, r0[1], s0[1], t0[1], "u0.ch1(52)");
      chan(3,  r1[0], s1[0], t1[0], "u1.ch0(3)");
      chan(2,  r1[1], s1[1], t1[1], "u1.ch1(2)");
    end
  end

  always @(posedge clk) begin
    if (!done) begin
      #1;
      chk("R2", f0, 1'b1, "fast_clk high phase u0");
      chk("R2", f1, 1'b1, "fast_clk high phase u1");
    end
  end

  // watchdog
  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // R9 is an elaboration-time refusal and cannot be exercised in a run.
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (317) @(negedge clk);
    // R10: asynchronous reset in mid-run, off the clock edge
    #1.5;
    rst_n = 1'b0;
    #0.5;
    chk("R10", |{r0, s0, t0, r1, s1, t1}, 1'b0, "outputs cleared without edge");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (400) @(negedge clk);
    #2;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule